// File: doc/BRIEF.md
# Translation Fault Sequencer

This block takes one memory access at a time (a read, a write or an instruction fetch) and steps it through the address translation checks in a fixed order. It ends with either a translated real address and its permissions, or a classified fault carrying a syndrome code. The checks run in this order: untranslated (real) mode, block translation, segment type, the no-execute attribute, and finally the page table walk. The block-match and table-walk engines sit outside. The sequencer drives them through request pulses and waits for their one-cycle responses.

An access is accepted when `ready` is high. The sequencer latches the access type, the effective address and the privilege bit. It also latches the segment register picked by effective address bits 31..28 from the 16-entry segment file. One cycle after the outcome is known, it raises either `done_ok` or `done_fault` for a single cycle. The result registers hold their value until the next outcome of the same kind.

Top module: `xlate_fault_seq`

## Requirements
- R1: An access is in real mode when it is a fetch (kind 2'b10) with `inst_xlate_on` low, or a read (2'b00) or write (2'b01) with `data_xlate_on` low. A real-mode access completes with `done_ok` in the cycle after acceptance, with `res_ra` equal to the effective address and `res_perm` = 3'b111. No sub-unit request is issued.
- R2: Any other access first pulses `blk_req`. If the block unit reports a hit, `walk_req` is never raised. If a hit's `blk_perm` covers the needed right, the result is `blk_ra` and `blk_perm`. Permission bits are: bit 0 read, bit 1 write, bit 2 execute.
- R3: A block hit whose permissions lack the needed right is a protection fault, with the same codes as R10.
- R4: The segment used is entry `req_ea[31:28]` of `seg_file`, where entry i is bits [32*i+31:32*i]. `walk_seg` presents that entry and `sub_ea` presents the effective address.
- R5: After a block miss, a segment with bit 31 set and bits 28..20 equal to 9'h07F completes with `res_ra` = {segment[3:0], ea[27:0]} and `res_perm` = 3'b111.
- R6: After a block miss, any other segment with bit 31 set faults. A fetch gives an instruction fault with code 32'h1000_0000. A read gives a data fault with code 32'h0400_0000, and a write gives 32'h0600_0000.
- R7: A fetch after a block miss from a segment with bit 31 clear and bit 28 set raises an instruction fault with code 32'h1000_0000, without a table walk. Reads and writes ignore bit 28 and go on to the walk.
- R8: `walk_key` is segment bit 29 when `user_mode` was high at acceptance, and segment bit 30 otherwise.
- R9: A walk miss gives an instruction fault with code 32'h4000_0000 for a fetch. For a data access it gives code 32'h4000_0000 on a read and 32'h4200_0000 on a write.
- R10: A walk hit whose `walk_perm` lacks the needed right is a protection fault. A fetch gives an instruction fault with code 32'h0800_0000. A data access gives 32'h0800_0000 on a read and 32'h0A00_0000 on a write. A walk hit that covers the right completes with `walk_ra` and `walk_perm`.
- R11: `exc_data` is 1 for a data storage fault and 0 for an instruction storage fault. Every data fault loads the effective address into `fault_addr`. Instruction faults and successful accesses leave `fault_addr` unchanged, and it is 0 after reset.
- R12: Only one access is in flight. `ready` is low from acceptance until the cycle in which `done_ok` or `done_fault` is raised. The two are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken when `ready` is high |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_ea | input | 32 | Effective address |
| inst_xlate_on | input | 1 | Instruction translation enable |
| data_xlate_on | input | 1 | Data translation enable |
| user_mode | input | 1 | Privilege: 1 user, 0 supervisor |
| seg_file | input | 512 | Sixteen 32-bit segment registers |
| ready | output | 1 | Idle, can accept an access |
| blk_req | output | 1 | Block lookup request pulse |
| sub_ea | output | 32 | Latched effective address for the sub-units |
| sub_fetch | output | 1 | Latched access is a fetch |
| sub_user | output | 1 | Latched privilege bit |
| blk_rsp_valid | input | 1 | Block lookup response strobe |
| blk_hit | input | 1 | Block lookup matched |
| blk_ra | input | 32 | Block real address |
| blk_perm | input | 3 | Block permissions |
| walk_req | output | 1 | Table walk request pulse |
| walk_seg | output | 32 | Selected segment register |
| walk_key | output | 1 | Protection key for the walk |
| walk_rsp_valid | input | 1 | Walk response strobe |
| walk_hit | input | 1 | Walk found an entry |
| walk_ra | input | 32 | Walk real address |
| walk_perm | input | 3 | Walk permissions |
| done_ok | output | 1 | Successful completion pulse |
| done_fault | output | 1 | Fault completion pulse |
| res_ra | output | 32 | Real address of the last success |
| res_perm | output | 3 | Permissions of the last success |
| exc_data | output | 1 | Last fault kind: 1 data, 0 instruction |
| syndrome | output | 32 | Code of the last fault |
| fault_addr | output | 32 | Effective address of the last data fault |

## Verification
On every cycle, the assertions cover the handshake rules: exclusive single-cycle completion, `ready` dropping for exactly the flight of one access, the block lookup being issued before any walk and a walk never following a block hit, the walk seeing the segment chosen by the accepted address, and the real-mode result. For every data fault they also check the fault address and the write flag of the syndrome. The priority among segment type, no-execute and walk outcomes, the exact syndrome values, the key choice, and the real addresses built from direct-store segments depend on segment contents and sub-unit answers. Only the bench's directed and random scenarios can show them, comparing against an independent model.

// File: rtl/xlate_fault_seq.sv
module xlate_fault_seq (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   req_kind,
  input  logic [31:0]  req_ea,
  input  logic         inst_xlate_on,
  input  logic         data_xlate_on,
  input  logic         user_mode,
  input  logic [511:0] seg_file,
  output logic         ready,
  output logic         blk_req,
  output logic [31:0]  sub_ea,
  output logic         sub_fetch,
  output logic         sub_user,
  input  logic         blk_rsp_valid,
  input  logic         blk_hit,
  input  logic [31:0]  blk_ra,
  input  logic [2:0]   blk_perm,
  output logic         walk_req,
  output logic [31:0]  walk_seg,
  output logic         walk_key,
  input  logic         walk_rsp_valid,
  input  logic         walk_hit,
  input  logic [31:0]  walk_ra,
  input  logic [2:0]   walk_perm,
  output logic         done_ok,
  output logic         done_fault,
  output logic [31:0]  res_ra,
  output logic [2:0]   res_perm,
  output logic         exc_data,
  output logic [31:0]  syndrome,
  output logic [31:0]  fault_addr
);
  localparam logic [31:0] C_NX   = 32'h1000_0000;
  localparam logic [31:0] C_MISS = 32'h4000_0000;
  localparam logic [31:0] C_PROT = 32'h0800_0000;
  localparam logic [31:0] C_DS   = 32'h0400_0000;
  localparam logic [31:0] C_WR   = 32'h0200_0000;
  localparam logic [8:0]  IO_ID  = 9'h07F;

  typedef enum logic [1:0] {S_IDLE, S_BLK, S_WALK} st_t;
  st_t st;

  logic [1:0]  kind_q;
  logic [31:0] ea_q, seg_q;
  logic        user_q;

  logic        is_fetch, is_write, real_now;
  logic [2:0]  need;
  logic        ev_ok, ev_fault, ev_walk;
  logic [31:0] ev_ra, ev_code;
  logic [2:0]  ev_perm;

  assign is_fetch  = (kind_q == 2'b10);
  assign is_write  = (kind_q == 2'b01);
  assign need      = is_fetch ? 3'b100 : (is_write ? 3'b010 : 3'b001);
  assign real_now  = (req_kind == 2'b10) ? !inst_xlate_on : !data_xlate_on;
  assign ready     = (st == S_IDLE);
  assign sub_ea    = ea_q;
  assign sub_fetch = is_fetch;
  assign sub_user  = user_q;
  assign walk_seg  = seg_q;
  assign walk_key  = user_q ? seg_q[29] : seg_q[30];

  always_comb begin
    ev_ok    = 1'b0;
    ev_fault = 1'b0;
    ev_walk  = 1'b0;
    ev_ra    = ea_q;
    ev_perm  = 3'b111;
    ev_code  = '0;
    if (st == S_BLK && blk_rsp_valid) begin
      if (blk_hit) begin
        if ((need & ~blk_perm) == 3'b000) begin
          ev_ok = 1'b1; ev_ra = blk_ra; ev_perm = blk_perm;
        end else begin
          ev_fault = 1'b1; ev_code = C_PROT;
        end
      end else if (seg_q[31]) begin
        if (seg_q[28:20] == IO_ID) begin
          ev_ok = 1'b1; ev_ra = {seg_q[3:0], ea_q[27:0]};
        end else begin
          ev_fault = 1'b1; ev_code = is_fetch ? C_NX : C_DS;
        end
      end else if (is_fetch && seg_q[28]) begin
        ev_fault = 1'b1; ev_code = C_NX;
      end else begin
        ev_walk = 1'b1;
      end
    end else if (st == S_WALK && walk_rsp_valid) begin
      if (!walk_hit) begin
        ev_fault = 1'b1; ev_code = C_MISS;
      end else if ((need & ~walk_perm) != 3'b000) begin
        ev_fault = 1'b1; ev_code = C_PROT;
      end else begin
        ev_ok = 1'b1; ev_ra = walk_ra; ev_perm = walk_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      kind_q     <= '0;
      ea_q       <= '0;
      seg_q      <= '0;
      user_q     <= 1'b0;
      blk_req    <= 1'b0;
      walk_req   <= 1'b0;
      done_ok    <= 1'b0;
      done_fault <= 1'b0;
      res_ra     <= '0;
      res_perm   <= '0;
      exc_data   <= 1'b0;
      syndrome   <= '0;
      fault_addr <= '0;
    end else begin
      blk_req    <= 1'b0;
      walk_req   <= 1'b0;
      done_ok    <= 1'b0;
      done_fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= req_kind;
          ea_q   <= req_ea;
          user_q <= user_mode;
          seg_q  <= seg_file[{req_ea[31:28], 5'b0} +: 32];
          if (real_now) begin
            done_ok  <= 1'b1;
            res_ra   <= req_ea;
            res_perm <= 3'b111;
          end else begin
            blk_req <= 1'b1;
            st      <= S_BLK;
          end
        end
        default: begin
          if (ev_walk) begin
            walk_req <= 1'b1;
            st       <= S_WALK;
          end
          if (ev_ok) begin
            done_ok  <= 1'b1;
            res_ra   <= ev_ra;
            res_perm <= ev_perm;
            st       <= S_IDLE;
          end
          if (ev_fault) begin
            done_fault <= 1'b1;
            exc_data   <= !is_fetch;
            syndrome   <= is_fetch ? ev_code : (ev_code | (is_write ? C_WR : 32'h0));
            if (!is_fetch) fault_addr <= ea_q;
            st         <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module xlate_fault_seq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [1:0]   req_kind,
  input logic [31:0]  req_ea,
  input logic         inst_xlate_on,
  input logic         data_xlate_on,
  input logic [511:0] seg_file,
  input logic         ready,
  input logic         blk_req,
  input logic         blk_rsp_valid,
  input logic         blk_hit,
  input logic         walk_req,
  input logic [31:0]  walk_seg,
  input logic         done_ok,
  input logic         done_fault,
  input logic [31:0]  res_ra,
  input logic [2:0]   res_perm,
  input logic         exc_data,
  input logic [31:0]  syndrome,
  input logic [31:0]  fault_addr
);
  logic        acc, acc_real;
  logic [31:0] rec_ea, rec_seg;
  logic        rec_wr;

  assign acc      = req_valid && ready;
  assign acc_real = acc && ((req_kind == 2'b10) ? !inst_xlate_on : !data_xlate_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_ea  <= '0;
      rec_seg <= '0;
      rec_wr  <= 1'b0;
    end else if (acc) begin
      rec_ea  <= req_ea;
      rec_seg <= seg_file[32*req_ea[31:28] +: 32];
      rec_wr  <= (req_kind == 2'b01);
    end
  end

  AST_REAL_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_real |=> (done_ok && res_ra == $past(req_ea) && res_perm == 3'b111)); // R1
  AST_BLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_real) |=> (blk_req && !walk_req)); // R2
  AST_WALK_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> $past(blk_rsp_valid && !blk_hit)); // R2
  AST_WALK_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (walk_seg == rec_seg)); // R4
  AST_DATA_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fault && exc_data) |-> (fault_addr == rec_ea)); // R11
  AST_INSTR_FAULT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fault && !exc_data) |-> $stable(fault_addr)); // R11
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fault && exc_data) |-> (syndrome[25] == rec_wr)); // R10
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fault)); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fault) |=> !(done_ok || done_fault) || $past(acc_real)); // R12
  AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ready == (done_ok || done_fault))); // R12
endmodule

bind xlate_fault_seq xlate_fault_seq_chk u_chk (.*);

// File: tb/xlate_fault_seq_bench.sv
module xlate_fault_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_kind = '0;
  logic [31:0]  req_ea = '0;
  logic         inst_xlate_on = 1'b0, data_xlate_on = 1'b0, user_mode = 1'b0;
  logic [511:0] seg_file;
  logic         ready, blk_req, sub_fetch, sub_user, walk_req, walk_key;
  logic [31:0]  sub_ea, walk_seg;
  logic         blk_rsp_valid = 1'b0, blk_hit = 1'b0;
  logic [31:0]  blk_ra = '0;
  logic [2:0]   blk_perm = '0;
  logic         walk_rsp_valid = 1'b0, walk_hit = 1'b0;
  logic [31:0]  walk_ra = '0;
  logic [2:0]   walk_perm = '0;
  logic         done_ok, done_fault, exc_data;
  logic [31:0]  res_ra, syndrome, fault_addr;
  logic [2:0]   res_perm;

  logic [31:0] segs [16];
  always_comb for (int i = 0; i < 16; i++) seg_file[i*32 +: 32] = segs[i];

  always #10 clk = ~clk;

  xlate_fault_seq u_xlate_fault_seq (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog R12: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (ea %h kind %0d)", r, act, exp, req_ea, req_kind);
    end
  endtask

  // expected outcome
  logic        e_blk, e_walk, e_ok, e_fault, e_data, e_key;
  logic [31:0] e_ra, e_code, e_seg, e_fa;
  logic [2:0]  e_perm;
  string       e_req;

  task automatic predict(input logic [1:0] k, input logic [31:0] ea, input logic ir, input logic dr,
                         input logic usr, input logic bh, input logic [31:0] bra, input logic [2:0] bp,
                         input logic wh, input logic [31:0] wra, input logic [2:0] wp);
    logic fetch, wr; logic [2:0] nd; logic [31:0] s;
    fetch = (k == 2'b10); wr = (k == 2'b01);
    nd = fetch ? 3'b100 : (wr ? 3'b010 : 3'b001);
    e_blk = 0; e_walk = 0; e_ok = 0; e_fault = 0; e_ra = 0; e_perm = 0; e_code = 0;
    e_key = 0; e_seg = 0; s = segs[ea[31:28]];
    if (fetch ? !ir : !dr) begin
      e_ok = 1; e_ra = ea; e_perm = 3'b111; e_req = "R1";
    end else begin
      e_blk = 1;
      if (bh) begin
        if ((nd & bp) != 0) begin e_ok = 1; e_ra = bra; e_perm = bp; e_req = "R2"; end
        else begin e_fault = 1; e_code = 32'h0800_0000; e_req = "R3"; end
      end else if (s[31]) begin
        if (s[28:20] == 9'h07F) begin e_ok = 1; e_ra = {s[3:0], ea[27:0]}; e_perm = 3'b111; e_req = "R5"; end
        else begin e_fault = 1; e_code = fetch ? 32'h1000_0000 : 32'h0400_0000; e_req = "R6"; end
      end else if (fetch && s[28]) begin
        e_fault = 1; e_code = 32'h1000_0000; e_req = "R7";
      end else begin
        e_walk = 1; e_seg = s; e_key = usr ? s[29] : s[30];
        if (!wh) begin e_fault = 1; e_code = 32'h4000_0000; e_req = "R9"; end
        else if ((nd & wp) == 0) begin e_fault = 1; e_code = 32'h0800_0000; e_req = "R10"; end
        else begin e_ok = 1; e_ra = wra; e_perm = wp; e_req = "R10"; end
      end
    end
    e_data = !fetch;
    if (e_fault && !fetch && wr) e_code = e_code | 32'h0200_0000;
    if (e_fault && !fetch) e_fa = ea;
  endtask

  task automatic run(input logic [1:0] k, input logic [31:0] ea, input logic ir, input logic dr,
                     input logic usr, input logic bh, input logic [31:0] bra, input logic [2:0] bp,
                     input logic wh, input logic [31:0] wra, input logic [2:0] wp, input int lat);
    logic saw_blk, saw_walk, got, g_key; logic [31:0] g_seg, g_sea; int cnt;
    predict(k, ea, ir, dr, usr, bh, bra, bp, wh, wra, wp);
    @(negedge clk);
    chk("R12 ready before request", {31'b0, ready}, 32'd1);
    req_kind = k; req_ea = ea; inst_xlate_on = ir; data_xlate_on = dr; user_mode = usr;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    saw_blk = 0; saw_walk = 0; got = 0; cnt = 0; g_key = 0; g_seg = 0; g_sea = 0;
    while (!got && cnt < 100) begin
      if (blk_req) begin
        saw_blk = 1;
        repeat (lat) @(negedge clk);
        blk_rsp_valid = 1; blk_hit = bh; blk_ra = bra; blk_perm = bp;
        @(negedge clk);
        blk_rsp_valid = 0; blk_hit = $urandom; blk_ra = $urandom;
      end else if (walk_req) begin
        saw_walk = 1; g_key = walk_key; g_seg = walk_seg; g_sea = sub_ea;
        repeat (lat) @(negedge clk);
        walk_rsp_valid = 1; walk_hit = wh; walk_ra = wra; walk_perm = wp;
        @(negedge clk);
        walk_rsp_valid = 0; walk_hit = $urandom; walk_ra = $urandom;
      end else if (done_ok || done_fault) begin
        got = 1;
      end else begin
        if (!ready == 0) chk("R12 ready low in flight", {31'b0, ready}, 32'd0);
        @(negedge clk); cnt++;
      end
    end
    chk("R12 completion seen", {31'b0, got}, 32'd1);
    chk({e_req, " block lookup issued (R2)"}, {31'b0, saw_blk}, {31'b0, e_blk});
    chk({e_req, " walk issued (R7)"}, {31'b0, saw_walk}, {31'b0, e_walk});
    chk({e_req, " done_ok"}, {31'b0, done_ok}, {31'b0, e_ok});
    chk({e_req, " done_fault"}, {31'b0, done_fault}, {31'b0, e_fault});
    chk("R12 exclusive", {31'b0, done_ok & done_fault}, 32'd0);
    if (e_walk) begin
      chk("R8 walk key", {31'b0, g_key}, {31'b0, e_key});
      chk("R4 walk segment", g_seg, e_seg);
      chk("R4 walk address", g_sea, ea);
    end
    if (e_ok) begin
      chk({e_req, " real address"}, res_ra, e_ra);
      chk({e_req, " permissions"}, {29'b0, res_perm}, {29'b0, e_perm});
    end
    if (e_fault) begin
      chk({e_req, " syndrome"}, syndrome, e_code);
      chk("R11 fault kind", {31'b0, exc_data}, {31'b0, e_data});
    end
    chk("R11 fault address", fault_addr, e_fa);
    @(negedge clk);
    chk("R12 single-cycle completion", {30'b0, done_ok, done_fault}, 32'd0);
  endtask

  initial begin
    logic [31:0] s, ea;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) segs[i] = 32'h0000_0000;
    e_fa = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {31'b0, ready}, 32'd1);
    chk("R12 reset done", {30'b0, done_ok, done_fault}, 32'd0);
    chk("R2 reset requests", {30'b0, blk_req, walk_req}, 32'd0);
    chk("R11 reset fault_addr", fault_addr, 32'd0);
    rst_n = 1;

    // R1 real mode
    run(2'b10, 32'h1234_5678, 0, 1, 0, 1, 32'hAAAA_0000, 3'b000, 1, 0, 3'b000, 0);
    run(2'b01, 32'hFEDC_BA98, 1, 0, 1, 1, 32'hAAAA_0000, 3'b000, 1, 0, 3'b000, 1);
    // R2 block hit and R3 block protection
    run(2'b00, 32'h3000_1000, 1, 1, 0, 1, 32'h8000_1000, 3'b001, 1, 0, 3'b111, 0);
    run(2'b01, 32'h3000_2000, 1, 1, 0, 1, 32'h8000_2000, 3'b101, 1, 0, 3'b111, 2);
    run(2'b10, 32'h3000_3000, 1, 1, 0, 1, 32'h8000_3000, 3'b011, 1, 0, 3'b111, 1);
    // R5 direct-store I/O segment
    segs[5] = 32'h87F0_000C;
    run(2'b01, 32'h5ABC_DEF0, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b000, 0);
    // R6 other direct-store segments
    segs[6] = 32'h8010_0000;
    run(2'b10, 32'h6000_0040, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b111, 0);
    run(2'b01, 32'h6000_0080, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b111, 1);
    run(2'b00, 32'h6000_00C0, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b111, 0);
    // R7 no-execute, and reads ignore it
    segs[7] = 32'h1000_0123;
    run(2'b10, 32'h7000_1000, 1, 1, 0, 0, 0, 3'b000, 1, 32'h1111_0000, 3'b111, 0);
    run(2'b00, 32'h7000_2000, 1, 1, 0, 0, 0, 3'b000, 1, 32'h2222_0000, 3'b001, 0);
    // R8 keys: user picks bit 29, supervisor bit 30
    segs[9] = 32'h2000_0456;
    run(2'b00, 32'h9000_0000, 1, 1, 1, 0, 0, 3'b000, 1, 32'h3333_0000, 3'b001, 0);
    run(2'b00, 32'h9000_0004, 1, 1, 0, 0, 0, 3'b000, 1, 32'h3333_0004, 3'b001, 0);
    // R9 walk miss per kind
    run(2'b00, 32'h9100_0000, 1, 1, 0, 0, 0, 3'b000, 0, 0, 3'b000, 1);
    run(2'b01, 32'h9200_0000, 1, 1, 0, 0, 0, 3'b000, 0, 0, 3'b000, 0);
    run(2'b10, 32'h9300_0000, 1, 1, 0, 0, 0, 3'b000, 0, 0, 3'b000, 2);
    // R10 walk protection per kind, and a granted walk
    run(2'b00, 32'h9400_0000, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b110, 0);
    run(2'b01, 32'h9500_0000, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b101, 0);
    run(2'b10, 32'h9600_0000, 1, 1, 0, 0, 0, 3'b000, 1, 0, 3'b011, 0);
    run(2'b10, 32'h9700_0000, 1, 1, 0, 0, 0, 3'b000, 1, 32'h4444_5000, 3'b100, 0);
    // R11 instruction fault after a data fault keeps the address
    run(2'b01, 32'h9800_0010, 1, 1, 0, 0, 0, 3'b000, 0, 0, 3'b000, 0);
    run(2'b10, 32'h9900_0020, 1, 1, 0, 0, 0, 3'b000, 0, 0, 3'b000, 0);

    for (int t = 0; t < 400; t++) begin
      ea = $urandom;
      s = $urandom;
      s[31] = ($urandom % 4 == 0);
      if (s[31] && ($urandom % 2 == 0)) s[28:20] = 9'h07F;
      segs[ea[31:28]] = s;
      run(2'($urandom % 3), ea, ($urandom % 5 != 0), ($urandom % 5 != 0), 1'($urandom),
          ($urandom % 3 == 0), $urandom, 3'($urandom), ($urandom % 4 != 0), $urandom,
          3'($urandom), int'($urandom % 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule